// File: doc/BRIEF.md
# Five-Master Shared Bus Arbiter

This block decides which of five bus masters owns a shared system bus. The masters are numbered 0 to 4: processor, DMA engine, bridge port, USB controller and display controller. A 32-bit configuration word, loaded through a simple write port, picks between two schedules. One is a plain rotation over all requesters. The other is a five-level programmable priority, where rotation settles ties between masters at the same level.

A grant is given in the same cycle a request appears on an idle bus. It then stays with that master until the transfer-done input is seen, so a transfer is never cut short. The arbiter outputs a one-hot grant vector and the binary index of the owning master. The next decision is taken on the first idle cycle after the done indication. Any configuration written in the meantime applies from that decision on.

Top module: `bus_arbiter5`

## Requirements
- R1: After reset the configuration word is 0x0000_0145, so the rotation schedule is active. No grant is asserted, the index output reads 0 and rotation begins its search at master 0.
- R2: Configuration bit 0 selects the schedule: 1 means rotation and 0 means priority. The 3-bit priority field of master i sits at bits [3i+3:3i+1].
- R3: In rotation mode the search for the next owner starts at the master after the one last granted and wraps from 4 to 0. Masters that are not requesting are skipped.
- R4: In priority mode the requesting master with the highest effective priority wins. Field value 5 is the highest and 1 the lowest.
- R5: A priority field value of 0, 6 or 7 is treated as priority 1.
- R6: In priority mode, requesters at the same winning level are served in rotation. Each level keeps its own pointer, and rotation mode keeps a separate one.
- R7: When the bus is idle and at least one request is present, a grant is asserted combinationally in that same cycle.
- R8: Once granted, grant_o and idx_o hold until done_i is sampled high with that grant. Changes on req_i in the meantime, including the owner dropping its request, do not move the grant.
- R9: A configuration write made during a transfer does not change the current owner. It governs the next arbitration decision.
- R10: At most one grant bit is high at any time. Whenever a grant is high, idx_o equals the index of that bit.
- R11: With no request pending on an idle bus, grant_o is all zero and idx_o keeps the index of the last granted master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 5 | Request line per master, bit i for master i |
| done_i | input | 1 | Current owner finishes its transfer this cycle |
| cfg_we_i | input | 1 | Load cfg_wdata_i into the configuration word |
| cfg_wdata_i | input | 32 | Configuration write data |
| gnt_o | output | 5 | One-hot grant |
| idx_o | output | 3 | Index of the granted or last granted master |

## Verification
The bench checks the wrap of the rotation pointer across sparse request patterns. A design that restarted its search at 0, or at the last winner, would grant the same master twice in a row. It holds a grant across changing requests and a configuration write, then checks that the first decision after done uses the new priority schedule. An arbiter that pre-empted, or applied the write early, would show the wrong owner. Ties at one level are checked against per-level pointers, and the illegal field values 0, 6 and 7 are checked to lose against a level-2 master. A decoder that treated 7 as high would let the wrong master win.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned NUM_MST  = 5;
  localparam int unsigned NUM_LVL  = 5;
  localparam int unsigned PRIO_W   = 3;
  localparam int unsigned CFG_W    = 32;
  localparam logic [31:0] CFG_RST  = 32'h0000_0145;

  typedef enum logic {
    MODE_PRIO = 1'b0,
    MODE_RR   = 1'b1
  } sched_mode_e;
endpackage

// File: rtl/arb_prio_decode.sv
module arb_prio_decode #(
  parameter int unsigned N     = 5,
  parameter int unsigned NL    = 5,
  parameter int unsigned PW    = 3,
  parameter int unsigned CW    = 32,
  localparam int unsigned LW   = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic [CW-1:0] cfg_i,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  cand_o,
  output logic [LW-1:0] lvl_o
);
  logic [LW-1:0] lvl [N];

  // level index 0..NL-1; out-of-range field values fold to the lowest level
  for (genvar i = 0; i < N; i++) begin : g_fld
    logic [PW-1:0] fld;
    assign fld = cfg_i[1 + PW*i +: PW];
    always_comb begin
      if (fld >= PW'(1) && fld <= PW'(NL)) lvl[i] = LW'(fld - PW'(1));
      else                                 lvl[i] = '0;
    end
  end

  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (lvl[i] > lvl_o)) lvl_o = lvl[i];
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) cand_o[i] = req_i[i] && (lvl[i] == lvl_o);
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int unsigned N   = 5,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] ptr_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  always_comb begin
    gnt_o   = '0;
    idx_o   = '0;
    valid_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr_i) + k;
      if (j >= int'(N)) j = j - int'(N);
      if (!valid_o && req_i[j]) begin
        valid_o  = 1'b1;
        gnt_o[j] = 1'b1;
        idx_o    = IW'(j);
      end
    end
  end
endmodule

// File: rtl/arb_ptr_bank.sv
module arb_ptr_bank #(
  parameter int unsigned N   = 5,
  parameter int unsigned NL  = 5,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned LW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic          rr_mode_i,
  input  logic [LW-1:0] lvl_i,
  input  logic [IW-1:0] win_i,
  output logic [IW-1:0] ptr_o
);
  logic [IW-1:0] rr_ptr_q;
  logic [IW-1:0] lvl_ptr_q [NL];
  logic [IW-1:0] nxt;

  assign nxt   = (win_i == IW'(N-1)) ? '0 : win_i + IW'(1);
  assign ptr_o = rr_mode_i ? rr_ptr_q : lvl_ptr_q[lvl_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rr_ptr_q <= '0;
    else if (upd_i && rr_mode_i)  rr_ptr_q <= nxt;
  end

  for (genvar l = 0; l < NL; l++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      lvl_ptr_q[l] <= '0;
      else if (upd_i && !rr_mode_i && lvl_i == LW'(l))  lvl_ptr_q[l] <= nxt;
    end
  end
endmodule

// File: rtl/bus_arbiter5.sv
module bus_arbiter5
  import arb_pkg::*;
#(
  parameter int unsigned N_MST  = NUM_MST,
  parameter int unsigned N_LVL  = NUM_LVL,
  parameter int unsigned P_W    = PRIO_W,
  parameter int unsigned C_W    = CFG_W,
  localparam int unsigned IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1,
  localparam int unsigned LVL_W = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] req_i,
  input  logic             done_i,
  input  logic             cfg_we_i,
  input  logic [C_W-1:0]   cfg_wdata_i,
  output logic [N_MST-1:0] gnt_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [C_W-1:0]   cfg_q;
  sched_mode_e      mode;
  logic [N_MST-1:0] prio_cand, cand, pick_gnt, gnt_q;
  logic [LVL_W-1:0] win_lvl;
  logic [IDX_W-1:0] ptr, pick_idx, idx_q;
  logic             pick_vld, busy_q, issue;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= C_W'(CFG_RST);
    else if (cfg_we_i) cfg_q <= cfg_wdata_i;
  end

  assign mode = sched_mode_e'(cfg_q[0]);

  arb_prio_decode #(.N(N_MST), .NL(N_LVL), .PW(P_W), .CW(C_W)) u_dec (
    .cfg_i  (cfg_q),
    .req_i  (req_i),
    .cand_o (prio_cand),
    .lvl_o  (win_lvl)
  );

  assign cand = (mode == MODE_RR) ? req_i : prio_cand;

  arb_ptr_bank #(.N(N_MST), .NL(N_LVL)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (issue),
    .rr_mode_i (mode == MODE_RR),
    .lvl_i     (win_lvl),
    .win_i     (pick_idx),
    .ptr_o     (ptr)
  );

  arb_rr_pick #(.N(N_MST)) u_pick (
    .req_i   (cand),
    .ptr_i   (ptr),
    .gnt_o   (pick_gnt),
    .idx_o   (pick_idx),
    .valid_o (pick_vld)
  );

  // decisions only on an idle bus, so config changes land at boundaries
  assign issue = !busy_q && pick_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      gnt_q  <= '0;
      idx_q  <= '0;
    end else if (issue) begin
      busy_q <= !done_i;
      gnt_q  <= pick_gnt;
      idx_q  <= pick_idx;
    end else if (busy_q && done_i) begin
      busy_q <= 1'b0;
    end
  end

  assign gnt_o = busy_q ? gnt_q : (pick_vld ? pick_gnt : '0);
  assign idx_o = busy_q ? idx_q : (pick_vld ? pick_idx : idx_q);
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  req_i,
  input logic          done_i,
  input logic [N-1:0]  gnt_o,
  input logic [IW-1:0] idx_o,
  input logic          busy_q
);
  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R10

  AST_IDX_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> (gnt_o == (N'(1) << idx_o))); // R10

  AST_SAME_CYCLE_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o)); // R7

  AST_HOLD_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> ($stable(gnt_o) && $stable(idx_o))); // R8

  AST_IDLE_NO_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|req_i) && !busy_q) |-> !(|gnt_o)); // R11
endmodule

bind bus_arbiter5 arb_checker #(.N(N_MST), .IW(IDX_W)) u_arb_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .done_i (done_i),
  .gnt_o  (gnt_o),
  .idx_o  (idx_o),
  .busy_q (busy_q)
);

// File: tb/bus_arbiter5_bench.sv
`timescale 1ns/1ps
module bus_arbiter5_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  req_i = '0;
  logic        done_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [4:0]  gnt_o;
  logic [2:0]  idx_o;

  int errors = 0;
  int checks = 0;

  always #2 clk_i = ~clk_i;

  bus_arbiter5 u_bus_arbiter5 (
    .clk_i, .rst_ni, .req_i, .done_i, .cfg_we_i, .cfg_wdata_i, .gnt_o, .idx_o
  );

  task automatic chk(input string tag, input logic [4:0] g_exp, input logic [2:0] i_exp);
    checks++;
    if (gnt_o !== g_exp || idx_o !== i_exp) begin
      errors++;
      $display("FAIL %s: gnt=%b idx=%0d expected gnt=%b idx=%0d", tag, gnt_o, idx_o, g_exp, i_exp);
    end
  endtask

  // single-cycle transfer: request, grant checked in same cycle, done at once
  task automatic xfer(input logic [4:0] mask, input int exp, input string tag);
    @(negedge clk_i);
    req_i = mask; done_i = 1'b1;
    #1 chk(tag, 5'(1 << exp), 3'(exp));
    @(posedge clk_i);
  endtask

  task automatic cfg_wr(input logic [31:0] v);
    @(negedge clk_i);
    req_i = '0; done_i = 1'b0; cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(posedge clk_i);
    #1 cfg_we_i = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    #1 chk("R1 reset idle", 5'b0, 3'd0);
  endtask

  task automatic t_rotate;
    xfer(5'b11111, 0, "R1 R3 rr first");
    xfer(5'b11111, 1, "R3 rr 1");
    xfer(5'b11111, 2, "R3 rr 2");
    xfer(5'b11111, 3, "R3 rr 3");
    xfer(5'b11111, 4, "R3 rr 4");
    xfer(5'b11111, 0, "R3 rr wrap");
    xfer(5'b01010, 1, "R3 sparse 1");
    xfer(5'b01010, 3, "R3 sparse 3");
    xfer(5'b01010, 1, "R3 sparse wrap");
  endtask

  task automatic t_idle;
    @(negedge clk_i);
    req_i = '0; done_i = 1'b0;
    #1 chk("R11 idle keeps idx", 5'b0, 3'd1);
    @(posedge clk_i);
  endtask

  task automatic t_hold;
    @(negedge clk_i);
    req_i = 5'b00100; done_i = 1'b0;
    #1 chk("R7 same-cycle grant", 5'b00100, 3'd2);
    @(negedge clk_i);
    req_i = 5'b11111; cfg_we_i = 1'b1; cfg_wdata_i = 32'h0000_A000; // prio mode, master4 at 5
    #1 chk("R8 hold under new reqs", 5'b00100, 3'd2);
    @(negedge clk_i);
    cfg_we_i = 1'b0; req_i = 5'b11011;
    #1 chk("R9 R8 hold after cfg write", 5'b00100, 3'd2);
    @(negedge clk_i);
    done_i = 1'b1;
    #1 chk("R8 owner until done", 5'b00100, 3'd2);
    @(negedge clk_i);
    req_i = 5'b11111; done_i = 1'b0;
    #1 chk("R9 new cfg at boundary", 5'b10000, 3'd4);
    @(negedge clk_i);
    done_i = 1'b1;
    @(posedge clk_i);
  endtask

  task automatic t_prio;
    cfg_wr(32'h0000_4DD2); // m0=1 m1=5 m2=3 m3=3 m4=2
    xfer(5'b11111, 1, "R4 top level wins");
    xfer(5'b10101, 2, "R4 level3 over level2");
    xfer(5'b01100, 3, "R6 tie after level ptr");
    xfer(5'b01100, 2, "R6 tie rotate");
    xfer(5'b01100, 3, "R6 tie rotate again");
    xfer(5'b10001, 4, "R4 level2 over level1");
  endtask

  task automatic t_fold;
    cfg_wr(32'h0000_470E); // m0=7 m1=0 m2=6 m3=1 m4=2
    xfer(5'b11111, 4, "R5 folded fields lose");
    xfer(5'b01111, 0, "R5 level1 ptr start");
    xfer(5'b01111, 1, "R5 R6 level1 rotate");
    xfer(5'b01111, 2, "R5 level1 rotate");
    xfer(5'b01111, 3, "R5 level1 rotate end");
  endtask

  task automatic t_mode_back;
    cfg_wr(32'h0000_0001);
    xfer(5'b11111, 3, "R2 R6 rr ptr kept apart");
    @(negedge clk_i);
    req_i = '0; done_i = 1'b0;
    #1 chk("R11 idle after rr", 5'b0, 3'd3);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_rotate();
    t_idle();
    t_hold();
    t_prio();
    t_fold();
    t_mode_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule